// File: doc/BRIEF.md
# Two-phase watchdog timer

This peripheral guards a processor against a hung program in two stages. Software programs a control word with an enable bit, a tick scale and two phase limits. Once enabled, the timer counts ticks. If software does not ping it in time, it first raises an early-warning interrupt and moves into a second phase. If that phase also runs out, it raises a final interrupt and sends a one-cycle reset request to the reset controller. The request goes to one of three outputs, picked by a mode field.

A tick is a power-of-two number of bus clocks. The base exponent is the parameter `BASE_SHIFT` (25 in silicon, small in simulation). A 2-bit scale field adds 0 to 3 to that exponent. Access is a simple bus with one-cycle writes and combinational reads.

The state machine has four states:
- `ST_IDLE`: stopped.
- `ST_PH1`: warning window.
- `ST_PH2`: reset window.
- `ST_FIRE`: one cycle of reset request.

Its transitions are:
- *arm* (IDLE to PH1 when enable is set).
- *disarm* (PH1 to IDLE when enable is cleared).
- *ping* (PH1 or PH2 to PH1).
- *warn* (PH1 to PH2 on the last phase-1 tick).
- *expire* (PH2 to FIRE on the last phase-2 tick).
- *retire* (FIRE to IDLE, always).

Top module: `twdog_top`

## Requirements
- R1: After reset, CTRL reads 0x0000_0001 (CPU-only mode, timer off). INTR reads 0, and both interrupts and all three reset outputs are low.
- R2: Offsets are 0x0 for the ping register, 0x4 for status and 0x8 for control. Control fields are:
  - enable at bit 31
  - scale at bits 30:29
  - phase-1 limit at bits 26:22
  - phase-2 limit at bits 19:15
  - reset mode at bits 1:0

  The ping register and all other control bits read as zero.
- R3: One tick lasts 2^(BASE_SHIFT+scale) bus clocks.
- R4: Counting starts on the clock edge after the one that writes enable. The warning interrupt (status bit 31, output `irq_warn`) rises (phase-1 limit + 1) ticks later.
- R5: The final interrupt (status bit 30, output `irq_final`) and the reset request appear together (phase-2 limit + 1) ticks after phase 2 starts.
- R6: The reset request is a one-cycle pulse:
  - mode 0 drives `soc_rst`
  - mode 1 drives `cpu_rst`
  - mode 2 drives `sw_rst`
  - mode 3 drives `soc_rst`

  Afterwards the enable bit reads 0 and the timer is idle.
- R7: Writing 1 to bit 31 of the ping register, in either phase, clears the tick and prescaler counters and restarts phase 1.
- R8: Status bits are write-1-to-clear. Writing 0 leaves them unchanged, and a bit being set by the timer wins over a clear in the same cycle.
- R9: Clearing enable before the warning stops the timer and clears its counters. A ping while disabled has no effect.
- R10: Once the warning has fired, clearing enable does not stop phase 2 from reaching the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_warn | output | 1 | Phase-1 interrupt level |
| irq_final | output | 1 | Phase-2 interrupt level |
| soc_rst | output | 1 | Full-chip reset request pulse |
| cpu_rst | output | 1 | CPU-only reset request pulse |
| sw_rst | output | 1 | Software reset request pulse |

## Verification
The hardest state to reach is phase 2 with outside interference. Three cases matter:
- enable cleared after the warning
- a ping arriving in phase 2
- a status clear racing the timer

Each must be hit on an exact clock edge. The bench runs with a 2-bit base shift, so a tick is only a few clocks. It computes every expiry edge from the programmed limits and writes the disturbing access a known number of edges after arming. It then samples one edge before and on the predicted edge, so an off-by-one tick or a lost phase shows up as a timing mismatch.

// File: rtl/twdog_pkg.sv
package twdog_pkg;
    localparam int LIM_W  = 5;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PH1,
        ST_PH2,
        ST_FIRE
    } twdog_state_e;

    localparam logic [1:0] MODE_SOC = 2'd0;
    localparam logic [1:0] MODE_CPU = 2'd1;
    localparam logic [1:0] MODE_SW  = 2'd2;

    localparam int BIT_EN   = 31;
    localparam int BIT_ST1  = 31;
    localparam int BIT_ST2  = 30;
    localparam int BIT_PING = 31;
endpackage

// File: rtl/twdog_tick.sv
module twdog_tick #(
    parameter int BASE_SHIFT = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] scale,
    output logic       tick
);
    localparam int CNT_W = BASE_SHIFT + 4;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (ONE << (BASE_SHIFT + 32'(scale))) - ONE;
        tick  = run && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || clr)  cnt <= '0;
        else if (tick)         cnt <= '0;
        else                   cnt <= cnt + ONE;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
endmodule

// File: rtl/twdog_regs.sv
module twdog_regs
    import twdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ph1_set,
    input  logic              ph2_set,
    input  logic              fire,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic [1:0]        scale,
    output logic [LIM_W-1:0]  lim1,
    output logic [LIM_W-1:0]  lim2,
    output logic [1:0]        mode,
    output logic              ping,
    output logic              st1,
    output logic              st2
);
    localparam logic [ADDR_W-1:0] OFF_PING = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8);

    logic wr_ctrl, wr_stat;
    logic unused_wbits;

    assign wr_ctrl = sel && we && (addr == OFF_CTRL);
    assign wr_stat = sel && we && (addr == OFF_STAT);
    assign ping    = sel && we && (addr == OFF_PING) && wdata[BIT_PING];
    assign unused_wbits = ^{wdata[28:27], wdata[21:20], wdata[14:2], wdata[29:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en    <= 1'b0;
            scale <= '0;
            lim1  <= '0;
            lim2  <= '0;
            mode  <= MODE_CPU;
        end else begin
            if (wr_ctrl) begin
                en    <= wdata[BIT_EN];
                scale <= wdata[30:29];
                lim1  <= wdata[26:22];
                lim2  <= wdata[19:15];
                mode  <= wdata[1:0];
            end
            if (fire) en <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1 <= 1'b0;
            st2 <= 1'b0;
        end else begin
            st1 <= ph1_set || (st1 && !(wr_stat && wdata[BIT_ST1]));
            st2 <= ph2_set || (st2 && !(wr_stat && wdata[BIT_ST2]));
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !we) begin
            if (addr == OFF_CTRL)
                rdata = {en, scale, 2'b00, lim1, 2'b00, lim2, 13'd0, mode};
            else if (addr == OFF_STAT)
                rdata = {st1, st2, 30'd0};
        end
    end

    AST_EN_DROPS_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !en); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[BIT_ST1] && !ph1_set) |=> !st1); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_set |=> st2); // R8
endmodule

// File: rtl/twdog_fsm.sv
module twdog_fsm
    import twdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ping,
    input  logic             tick,
    input  logic [LIM_W-1:0] lim1,
    input  logic [LIM_W-1:0] lim2,
    input  logic [1:0]       mode,
    output logic             running,
    output logic             ping_hit,
    output logic             ph1_done,
    output logic             ph2_done,
    output logic             fire,
    output logic             soc_rst,
    output logic             cpu_rst,
    output logic             sw_rst
);
    twdog_state_e state, nxt;
    logic [LIM_W-1:0] tcnt;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (en) nxt = ST_PH1;
            ST_PH1: begin
                if (!en)                        nxt = ST_IDLE;
                else if (ping)                  nxt = ST_PH1;
                else if (tick && tcnt == lim1)  nxt = ST_PH2;
            end
            ST_PH2: begin
                if (ping)                       nxt = ST_PH1;
                else if (tick && tcnt == lim2)  nxt = ST_FIRE;
            end
            ST_FIRE:                            nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // tick counter within the current phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                tcnt <= '0;
        else if (!running || ping_hit || nxt != state) tcnt <= '0;
        else if (tick)                             tcnt <= tcnt + 1'b1;
    end

    // outputs
    always_comb begin
        running  = (state == ST_PH1) || (state == ST_PH2);
        ping_hit = ping && (((state == ST_PH1) && en) || (state == ST_PH2));
        ph1_done = (state == ST_PH1) && (nxt == ST_PH2);
        ph2_done = (state == ST_PH2) && (nxt == ST_FIRE);
        fire     = (state == ST_FIRE);
        soc_rst  = fire && (mode != MODE_CPU) && (mode != MODE_SW);
        cpu_rst  = fire && (mode == MODE_CPU);
        sw_rst   = fire && (mode == MODE_SW);
    end

    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soc_rst, cpu_rst, sw_rst})); // R6
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_rst || cpu_rst || sw_rst) |=> !(soc_rst || cpu_rst || sw_rst)); // R6
    AST_FIRE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRE) |=> (state == ST_IDLE)); // R6
    AST_PH2_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH2) |=> (state != ST_IDLE)); // R10
endmodule

// File: rtl/twdog_top.sv
module twdog_top
    import twdog_pkg::*;
#(
    parameter int BASE_SHIFT = 25,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_warn,
    output logic              irq_final,
    output logic              soc_rst,
    output logic              cpu_rst,
    output logic              sw_rst
);
    logic             en, ping, st1, st2;
    logic [1:0]       scale, mode;
    logic [LIM_W-1:0] lim1, lim2;
    logic             running, ping_hit, ph1_done, ph2_done, fire, tick;

    twdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata),
        .ph1_set(ph1_done), .ph2_set(ph2_done), .fire(fire),
        .rdata(bus_rdata), .en(en), .scale(scale), .lim1(lim1),
        .lim2(lim2), .mode(mode), .ping(ping), .st1(st1), .st2(st2)
    );

    twdog_tick #(.BASE_SHIFT(BASE_SHIFT)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(running), .clr(ping_hit),
        .scale(scale), .tick(tick)
    );

    twdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .ping(ping), .tick(tick),
        .lim1(lim1), .lim2(lim2), .mode(mode),
        .running(running), .ping_hit(ping_hit), .ph1_done(ph1_done),
        .ph2_done(ph2_done), .fire(fire),
        .soc_rst(soc_rst), .cpu_rst(cpu_rst), .sw_rst(sw_rst)
    );

    assign irq_warn  = st1;
    assign irq_final = st2;

    AST_IRQ_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_rst || cpu_rst || sw_rst) |-> irq_final); // R5
endmodule

// File: tb/tb_twdog_top.sv
module tb_twdog_top;
    localparam int SH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_warn, irq_final, soc_rst, cpu_rst, sw_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    twdog_top #(.BASE_SHIFT(SH), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_warn(irq_warn), .irq_final(irq_final),
        .soc_rst(soc_rst), .cpu_rst(cpu_rst), .sw_rst(sw_rst)
    );

    // {scale[13:12], lim1[11:7], lim2[6:2], mode[1:0]}
    localparam logic [13:0] VEC [6] = '{
        {2'd0, 5'd0,  5'd0,  2'd0},
        {2'd1, 5'd2,  5'd1,  2'd1},
        {2'd2, 5'd0,  5'd3,  2'd2},
        {2'd3, 5'd4,  5'd0,  2'd3},
        {2'd0, 5'd31, 5'd31, 2'd1},
        {2'd1, 5'd1,  5'd5,  2'd2}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input logic [1:0] sc,
                                              input logic [4:0] l1, input logic [4:0] l2,
                                              input logic [1:0] md);
        return {en, sc, 2'b00, l1, 2'b00, l2, 13'd0, md};
    endfunction

    function automatic logic [2:0] rst_exp(input logic [1:0] md);
        return (md == 2'd1) ? 3'b010 : (md == 2'd2) ? 3'b001 : 3'b100;
    endfunction

    task automatic wait_fire();
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            if (soc_rst || cpu_rst || sw_rst) break;
        end
        edges(1);
        wr(4'h4, 32'hC000_0000);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int L, tw, tf;
        logic [1:0] sc, md;
        logic [4:0] l1, l2;

        edges(3);
        #1;
        @(negedge clk) rst_n = 1'b1;
        edges(1);

        // R1 reset state
        rd(4'h8, d); chk(d == 32'h1, "R1 ctrl", d, 32'h1);
        rd(4'h4, d); chk(d == 32'h0, "R1 intr", d, 32'h0);
        chk({irq_warn, irq_final, soc_rst, cpu_rst, sw_rst} == 5'b0, "R1 outputs",
            {27'd0, irq_warn, irq_final, soc_rst, cpu_rst, sw_rst}, 32'h0);

        // R2 field layout and zero bits
        wr(4'h8, 32'h7FFF_FFFF);
        rd(4'h8, d); chk(d == 32'h67CF_8003, "R2 ctrl readback", d, 32'h67CF_8003);
        rd(4'h0, d); chk(d == 32'h0, "R2 ping reg reads zero", d, 32'h0);
        wr(4'h8, 32'h1);

        // R3 R4 R5 R6 table walk
        foreach (VEC[k]) begin
            {sc, l1, l2, md} = VEC[k];
            L  = 1 << (SH + sc);
            tw = 1 + (l1 + 1) * L;
            tf = tw + (l2 + 1) * L;
            wr(4'h8, ctrl_word(1'b1, sc, l1, l2, md));
            edges(tw - 1);
            chk(irq_warn == 1'b0, "R3 R4 warn early", {31'd0, irq_warn}, 32'd0);
            edges(1);
            chk(irq_warn == 1'b1, "R3 R4 warn on time", {31'd0, irq_warn}, 32'd1);
            edges(tf - tw - 1);
            chk({soc_rst, cpu_rst, sw_rst} == 3'b0 && !irq_final, "R5 no early reset",
                {28'd0, irq_final, soc_rst, cpu_rst, sw_rst}, 32'd0);
            edges(1);
            chk({soc_rst, cpu_rst, sw_rst} == rst_exp(md), "R6 reset output by mode",
                {29'd0, soc_rst, cpu_rst, sw_rst}, {29'd0, rst_exp(md)});
            chk(irq_final == 1'b1, "R5 final irq", {31'd0, irq_final}, 32'd1);
            edges(1);
            chk({soc_rst, cpu_rst, sw_rst} == 3'b0, "R6 single-cycle pulse",
                {29'd0, soc_rst, cpu_rst, sw_rst}, 32'd0);
            rd(4'h8, d); chk(d[31] == 1'b0, "R6 enable cleared", d, {1'b0, d[30:0]});
            wr(4'h4, 32'hC000_0000);
            chk(!irq_warn && !irq_final, "R8 clear both", {30'd0, irq_warn, irq_final}, 32'd0);
        end

        // R7 ping in phase 1 (scale 0, lim1 1: warn 9 edges after arming)
        wr(4'h8, ctrl_word(1'b1, 2'd0, 5'd1, 5'd0, 2'd1));
        edges(5);
        wr(4'h0, 32'h8000_0000);
        edges(7);
        chk(irq_warn == 1'b0, "R7 ping delays warn", {31'd0, irq_warn}, 32'd0);
        edges(1);
        chk(irq_warn == 1'b1, "R7 warn after ping", {31'd0, irq_warn}, 32'd1);
        wait_fire();

        // R7 ping in phase 2 returns to phase 1 (lim1 0, lim2 3)
        wr(4'h8, ctrl_word(1'b1, 2'd0, 5'd0, 5'd3, 2'd2));
        edges(5);
        chk(irq_warn == 1'b1, "R7 warn before phase-2 ping", {31'd0, irq_warn}, 32'd1);
        wr(4'h0, 32'h8000_0000);
        edges(15);
        chk(!sw_rst, "R7 no reset at old expiry", {31'd0, sw_rst}, 32'd0);
        edges(4);
        chk(!sw_rst, "R7 no reset one edge early", {31'd0, sw_rst}, 32'd0);
        edges(1);
        chk(sw_rst, "R7 reset after restarted phases", {31'd0, sw_rst}, 32'd1);
        edges(1);
        wr(4'h4, 32'hC000_0000);

        // R9 disable before warning, ping while disabled
        wr(4'h8, ctrl_word(1'b1, 2'd0, 5'd1, 5'd0, 2'd0));
        edges(3);
        wr(4'h8, ctrl_word(1'b0, 2'd0, 5'd1, 5'd0, 2'd0));
        edges(40);
        chk(!irq_warn && !soc_rst, "R9 stopped", {30'd0, irq_warn, soc_rst}, 32'd0);
        wr(4'h0, 32'h8000_0000);
        edges(40);
        rd(4'h4, d);
        chk(d == 32'h0 && !soc_rst, "R9 ping ignored while disabled", d, 32'h0);
        wr(4'h8, ctrl_word(1'b1, 2'd0, 5'd1, 5'd0, 2'd0));
        edges(8);
        chk(irq_warn == 1'b0, "R9 fresh count early", {31'd0, irq_warn}, 32'd0);
        edges(1);
        chk(irq_warn == 1'b1, "R9 fresh count on time", {31'd0, irq_warn}, 32'd1);
        wait_fire();

        // R10 disable after warning does not stop (lim2 2: reset at edge 17)
        wr(4'h8, ctrl_word(1'b1, 2'd0, 5'd0, 5'd2, 2'd1));
        edges(5);
        chk(irq_warn == 1'b1, "R10 warn fired", {31'd0, irq_warn}, 32'd1);
        wr(4'h8, ctrl_word(1'b0, 2'd0, 5'd0, 5'd2, 2'd1));
        edges(10);
        chk(!cpu_rst, "R10 no reset early", {31'd0, cpu_rst}, 32'd0);
        edges(1);
        chk(cpu_rst, "R10 reset despite disable", {31'd0, cpu_rst}, 32'd1);
        edges(1);
        wr(4'h4, 32'hC000_0000);

        // R8 write-1-to-clear details (lim2 7: reset at edge 37)
        wr(4'h8, ctrl_word(1'b1, 2'd0, 5'd0, 5'd7, 2'd0));
        edges(5);
        wr(4'h4, 32'h0);
        chk(irq_warn == 1'b1, "R8 write zero keeps", {31'd0, irq_warn}, 32'd1);
        wr(4'h4, 32'h4000_0000);
        chk(irq_warn == 1'b1, "R8 other bit keeps", {31'd0, irq_warn}, 32'd1);
        wr(4'h4, 32'h8000_0000);
        chk(irq_warn == 1'b0, "R8 bit31 clears", {31'd0, irq_warn}, 32'd0);
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (soc_rst) break;
        end
        chk(soc_rst && irq_final && !irq_warn, "R8 final set, warn stays clear",
            {29'd0, soc_rst, irq_final, irq_warn}, 32'd6);
        edges(1);
        wr(4'h4, 32'h4000_0000);
        chk(irq_final == 1'b0, "R8 bit30 clears", {31'd0, irq_final}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule